// File: doc/BRIEF.md
# Hypervisor Last-Level Translation Invalidate Unit

This block holds a small fully associative translation cache and a maintenance port that carries out one system operation: invalidating, by virtual page, the hypervisor-regime entries that were cached from the final level of a table walk. The maintenance port takes the decoded coprocessor-write fields of an operation, its 32-bit register operand, the current exception level and a few configuration bits. It then decides whether the operation runs, traps to the hypervisor, or is undefined.

When the operation runs, every matching entry is cleared in one clock edge. Only this cache is affected, and nothing is broadcast. A fill port loads entries, and a combinational lookup port translates a virtual page within a regime. Each accepted operation returns a result code, a trap syndrome and a one-cycle done pulse in the cycle after acceptance.

Top module: `hyp_tlb_inv`

## Requirements
- R1: An operation is accepted only when `op_valid` is high and the fields are coprocessor 15, opc1=4, CRn=8, CRm=7, opc2=5. An accepted operation raises `res_done` for exactly the next cycle. Any other field combination produces no done pulse and changes no entry.
- R2: The result code is 2'b00 for executed, 2'b01 for trapped and 2'b10 for undefined, and it is never 2'b11. If `cfg_hyp32` is low, the result is undefined at every level.
- R3: At level 0 (`cur_el`=0), the result is undefined.
- R4: At level 1, the result is trapped with `res_synd`=6'h03 when `cfg_el2_en` and `hyp_trap_t8` are both high; otherwise it is undefined. `res_synd` is 0 whenever the result is not trapped, and whenever `res_done` is low.
- R5: At level 2, the operation executes. It clears every entry that is valid, tagged hypervisor, flagged last-level, and whose page equals `op_data[31:12]`. Bits [11:0] of the operand are ignored.
- R6: An executed operation keeps entries that are not last-level, not hypervisor-tagged, or whose page differs.
- R7: At level 3, the result is undefined when `cfg_el2_present` is low. Otherwise the operation executes as in R5.
- R8: A lookup hits when an entry is valid with an equal page and an equal regime tag, and returns that entry's physical page; the lowest index wins. A lookup in the same cycle as an accepted invalidate sees the entries before invalidation.
- R9: A fill writes all fields of the indexed entry and sets it valid. A fill to an entry in the same cycle as an invalidation that matches it leaves the filled entry valid.
- R10: After reset, no entry is valid, and `res_done`, `res_code` and `res_synd` are 0.
- R11: Trapped and undefined results change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one cache entry |
| fill_idx | input | IDX_W | Entry index to write |
| fill_vpn | input | 20 | Virtual page of the new entry |
| fill_hyp | input | 1 | Entry belongs to the hypervisor regime |
| fill_last | input | 1 | Entry came from the final walk level |
| fill_ppn | input | PPN_W | Physical page of the new entry |
| lk_vpn | input | 20 | Lookup virtual page |
| lk_hyp | input | 1 | Lookup regime tag |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | PPN_W | Physical page of the match (0 on miss) |
| op_valid | input | 1 | Maintenance operation presented |
| op_cp | input | 4 | Coprocessor number |
| op_opc1 | input | 3 | First opcode field |
| op_crn | input | 4 | CRn field |
| op_crm | input | 4 | CRm field |
| op_opc2 | input | 3 | Second opcode field |
| op_data | input | 32 | Register operand; page in [31:12] |
| cur_el | input | 2 | Current exception level |
| cfg_hyp32 | input | 1 | 32-bit hypervisor feature configured |
| cfg_el2_present | input | 1 | Hypervisor level exists |
| cfg_el2_en | input | 1 | Hypervisor level enabled for the current state |
| hyp_trap_t8 | input | 1 | Hypervisor trap bit for this operation group |
| res_done | output | 1 | One-cycle pulse after an accepted operation |
| res_code | output | 2 | Result code |
| res_synd | output | 6 | Trap syndrome |

## Verification
On every cycle, the assertions check the result path: that a done pulse follows only a correctly encoded operation, the priority of the feature, level-0 and level-3 presence checks, the trap syndrome value, and the rule that the syndrome is zero outside traps. Which entries survive an invalidate cannot be seen from the result ports. The bench therefore shows it by sweeping lookups over a model of the cache after every step, which covers the last-level, regime and ignored-offset cases. Directed scenarios cover the same-cycle lookup and the collision between a fill and an invalidate.

// File: rtl/hyp_tlb_inv.sv
module hyp_tlb_inv #(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_hyp,
  input  logic             fill_last,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hyp,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             op_valid,
  input  logic [3:0]       op_cp,
  input  logic [2:0]       op_opc1,
  input  logic [3:0]       op_crn,
  input  logic [3:0]       op_crm,
  input  logic [2:0]       op_opc2,
  input  logic [31:0]      op_data,
  input  logic [1:0]       cur_el,
  input  logic             cfg_hyp32,
  input  logic             cfg_el2_present,
  input  logic             cfg_el2_en,
  input  logic             hyp_trap_t8,
  output logic             res_done,
  output logic [1:0]       res_code,
  output logic [5:0]       res_synd
);
  localparam logic [1:0] RC_EXEC  = 2'b00;
  localparam logic [1:0] RC_TRAP  = 2'b01;
  localparam logic [1:0] RC_UNDEF = 2'b10;
  localparam logic [5:0] TRAP_SYN = 6'h03;

  logic [ENTRIES-1:0] e_valid, e_hyp, e_last, inv_hit;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];

  wire op_ours = op_valid && op_cp == 4'd15 && op_opc1 == 3'd4 &&
                 op_crn == 4'd8 && op_crm == 4'd7 && op_opc2 == 3'd5;

  logic [1:0] dec_code;
  always_comb begin
    if (!cfg_hyp32) dec_code = RC_UNDEF;
    else begin
      unique case (cur_el)
        2'd0:    dec_code = RC_UNDEF;
        2'd1:    dec_code = (cfg_el2_en && hyp_trap_t8) ? RC_TRAP : RC_UNDEF;
        2'd2:    dec_code = RC_EXEC;
        default: dec_code = cfg_el2_present ? RC_EXEC : RC_UNDEF;
      endcase
    end
  end

  wire              do_inv  = op_ours && dec_code == RC_EXEC;
  wire [VPN_W-1:0]  inv_vpn = op_data[31:12];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign inv_hit[i] = do_inv && e_valid[i] && e_hyp[i] && e_last[i] &&
                        e_vpn[i] == inv_vpn;
    wire fill_me = fill_en && fill_idx == IDX_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_valid[i] <= 1'b0;
        e_hyp[i]   <= 1'b0;
        e_last[i]  <= 1'b0;
        e_vpn[i]   <= '0;
        e_ppn[i]   <= '0;
      end else if (fill_me) begin
        e_valid[i] <= 1'b1;
        e_hyp[i]   <= fill_hyp;
        e_last[i]  <= fill_last;
        e_vpn[i]   <= fill_vpn;
        e_ppn[i]   <= fill_ppn;
      end else if (inv_hit[i]) begin
        e_valid[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_valid[i] && e_vpn[i] == lk_vpn && e_hyp[i] == lk_hyp) begin
        lk_hit = 1'b1;
        lk_ppn = e_ppn[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done <= 1'b0;
      res_code <= RC_EXEC;
      res_synd <= '0;
    end else begin
      res_done <= op_ours;
      res_code <= op_ours ? dec_code : RC_EXEC;
      res_synd <= (op_ours && dec_code == RC_TRAP) ? TRAP_SYN : 6'h00;
    end
  end
endmodule

module hyp_tlb_inv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_cp,
  input logic [2:0]  op_opc1,
  input logic [3:0]  op_crn,
  input logic [3:0]  op_crm,
  input logic [2:0]  op_opc2,
  input logic [1:0]  cur_el,
  input logic        cfg_hyp32,
  input logic        cfg_el2_present,
  input logic        cfg_el2_en,
  input logic        hyp_trap_t8,
  input logic        res_done,
  input logic [1:0]  res_code,
  input logic [5:0]  res_synd
);
  // R1
  done_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(op_valid && op_cp == 4'd15 && op_opc1 == 3'd4 &&
                       op_crn == 4'd8 && op_crm == 4'd7 && op_opc2 == 3'd5));
  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> res_code != 2'b11);
  // R2
  no_feature_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !$past(cfg_hyp32)) |-> res_code == 2'b10);
  // R3
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && $past(cur_el) == 2'd0) |-> res_code == 2'b10);
  // R4
  trap_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_code == 2'b01) |-> (res_synd == 6'h03 && $past(cur_el) == 2'd1
                                         && $past(cfg_el2_en && hyp_trap_t8)));
  // R4
  synd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_done && res_code == 2'b01) |-> res_synd == 6'h00);
  // R7
  el3_absent_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && $past(cur_el) == 2'd3 && !$past(cfg_el2_present)) |-> res_code == 2'b10);
endmodule

bind hyp_tlb_inv hyp_tlb_inv_chk u_chk (.*);

// File: tb/hyp_tlb_inv_bench.sv
`timescale 1ns/1ps
module hyp_tlb_inv_bench;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int PW = 20;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic fill_en = 0, fill_hyp = 0, fill_last = 0, lk_hyp = 0, lk_hit;
  logic [IW-1:0] fill_idx = 0;
  logic [19:0] fill_vpn = 0, lk_vpn = 0;
  logic [PW-1:0] fill_ppn = 0, lk_ppn;
  logic op_valid = 0, cfg_hyp32 = 0, cfg_el2_present = 0, cfg_el2_en = 0, hyp_trap_t8 = 0;
  logic [3:0] op_cp = 0, op_crn = 0, op_crm = 0;
  logic [2:0] op_opc1 = 0, op_opc2 = 0;
  logic [31:0] op_data = 0;
  logic [1:0] cur_el = 0, res_code;
  logic res_done;
  logic [5:0] res_synd;

  hyp_tlb_inv #(.ENTRIES(N), .PPN_W(PW)) u_hyp_tlb_inv (.*);

  int tests = 0, fails = 0;
  bit m_v[N], m_h[N], m_l[N];
  logic [19:0] m_vpn[N];
  logic [PW-1:0] m_ppn[N];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] f_code(bit h32, bit pres, bit en, bit t8, logic [1:0] el);
    if (!h32) return 2'b10;
    case (el)
      2'd0: return 2'b10;
      2'd1: return (en && t8) ? 2'b01 : 2'b10;
      2'd2: return 2'b00;
      default: return pres ? 2'b00 : 2'b10;
    endcase
  endfunction

  task automatic sweep(string req);
    for (int i = 0; i < N; i++) begin
      bit eh = 0;
      logic [PW-1:0] ep = '0;
      lk_vpn = m_vpn[i];
      lk_hyp = m_h[i];
      for (int j = N - 1; j >= 0; j--)
        if (m_v[j] && m_vpn[j] == m_vpn[i] && m_h[j] == m_h[i]) begin eh = 1; ep = m_ppn[j]; end
      #0.1;
      chk(req, {31'd0, lk_hit}, {31'd0, eh});
      chk(req, 32'(lk_ppn), 32'(ep));
    end
  endtask

  task automatic step(bit f, int fi, logic [19:0] fv, bit fh, bit fl, logic [PW-1:0] fp,
                      bit ov, bit good, logic [31:0] d, logic [1:0] el,
                      bit h32, bit pres, bit en, bit t8, string req);
    logic [1:0] ec;
    bit ours;
    @(negedge clk);
    fill_en = f; fill_idx = IW'(fi); fill_vpn = fv; fill_hyp = fh; fill_last = fl; fill_ppn = fp;
    op_valid = ov; op_data = d; cur_el = el;
    cfg_hyp32 = h32; cfg_el2_present = pres; cfg_el2_en = en; hyp_trap_t8 = t8;
    op_cp = 4'd15; op_opc1 = 3'd4; op_crn = 4'd8; op_crm = 4'd7; op_opc2 = 3'd5;
    if (!good) case ($urandom_range(0, 4))
      0: op_cp = 4'd14; 1: op_opc1 = 3'd0; 2: op_crn = 4'd7; 3: op_crm = 4'd3; default: op_opc2 = 3'd1;
    endcase
    ours = ov && good;
    ec = f_code(h32, pres, en, t8, el);
    if (ours && ec == 2'b00)
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_h[i] && m_l[i] && m_vpn[i] == d[31:12] && !(f && fi == i)) m_v[i] = 0;
    if (f) begin m_v[fi] = 1; m_h[fi] = fh; m_l[fi] = fl; m_vpn[fi] = fv; m_ppn[fi] = fp; end
    @(negedge clk);
    fill_en = 0; op_valid = 0;
    chk({req, " R1 done"}, {31'd0, res_done}, {31'd0, ours});
    chk({req, " R2 code"}, {30'd0, res_code}, ours ? {30'd0, ec} : 32'd0);
    chk({req, " R4 synd"}, {26'd0, res_synd}, (ours && ec == 2'b01) ? 32'h3 : 32'd0);
    sweep({req, " R5 R6 R11 entries"});
  endtask

  initial begin : wd
    #(5.0 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_h[i] = 0; m_l[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10 done", {31'd0, res_done}, 0);
    chk("R10 code", {30'd0, res_code}, 0);
    chk("R10 synd", {26'd0, res_synd}, 0);
    rst_n = 1;
    @(negedge clk);
    lk_vpn = 0; lk_hyp = 0; #0.1;
    chk("R10 empty lookup", {31'd0, lk_hit}, 0);

    // R9 fills with the four kinds of entry on one page
    step(1, 0, 20'hABCDE, 1, 1, 20'h11111, 0, 1, 0, 2, 1, 1, 1, 0, "R9 fill0");
    step(1, 1, 20'hABCDE, 1, 0, 20'h22222, 0, 1, 0, 2, 1, 1, 1, 0, "R9 fill1");
    step(1, 2, 20'hABCDE, 0, 1, 20'h33333, 0, 1, 0, 2, 1, 1, 1, 0, "R9 fill2");
    step(1, 3, 20'hABCDF, 1, 1, 20'h44444, 0, 1, 0, 2, 1, 1, 1, 0, "R9 fill3");
    // R3 / R2 / R4 / R7 non-executing, entries unchanged (R11)
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDE000, 0, 1, 1, 1, 1, "R3 el0");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDE000, 2, 0, 1, 1, 1, "R2 nofeat");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDE000, 1, 1, 1, 1, 1, "R4 trap");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDE000, 1, 1, 1, 0, 1, "R4 notrap en");
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDE000, 3, 1, 0, 1, 1, "R7 el3 absent");
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'hABCDE000, 2, 1, 1, 1, 1, "R1 bad fields");

    // R8 same-cycle lookup sees old entry, R5 offset bits ignored, R6 others kept
    @(negedge clk);
    op_valid = 1; op_cp = 4'd15; op_opc1 = 3'd4; op_crn = 4'd8; op_crm = 4'd7; op_opc2 = 3'd5;
    op_data = 32'hABCDEFFF; cur_el = 2; cfg_hyp32 = 1;
    lk_vpn = 20'hABCDE; lk_hyp = 1; #0.1;
    chk("R8 same-cycle hit", {31'd0, lk_hit}, 1);
    chk("R8 same-cycle ppn", 32'(lk_ppn), 32'h11111);
    @(negedge clk);
    op_valid = 0;
    m_v[0] = 0;
    chk("R5 exec code", {30'd0, res_code}, 0);
    lk_vpn = 20'hABCDE; lk_hyp = 1; #0.1;
    chk("R6 non-last kept", 32'(lk_ppn), 32'h22222);
    sweep("R5 R6 after exec");

    // R7 el3 executes; R9 fill collides with invalidate
    step(1, 3, 20'hABCDF, 1, 1, 20'h55555, 1, 1, 32'hABCDF123, 3, 1, 1, 0, 0, "R9 R7 collide");
    lk_vpn = 20'hABCDF; lk_hyp = 1; #0.1;
    chk("R9 fill wins", 32'(lk_ppn), 32'h55555);
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'hABCDF000, 3, 1, 1, 0, 0, "R7 el3 exec");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [19:0] v = 20'h10 + 20'($urandom_range(0, 3));
      logic [19:0] dv = 20'h10 + 20'($urandom_range(0, 3));
      step($urandom_range(0, 9) < 4, $urandom_range(0, N - 1), v,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, PW'($urandom),
           $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 8,
           {dv, 12'($urandom)}, 2'($urandom_range(0, 3)),
           $urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "rand");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule